// File: doc/BRIEF.md
# DMA Channel Chaining Trigger

This block links pairs of DMA channels so that a completion event on one channel (the source of a chain) starts another channel (the destination) in hardware, with no software step between them. It holds a small number of chaining groups, two by default. Each group lives in one 32-bit configuration word on a plain register read/write port. The word names a source channel, a destination channel, which completion events count as a trigger, a per-group interrupt-mask field and an enable. Each channel's transfer setup stays with the data mover. This block only watches the per-channel completion pulses and emits per-channel start-request pulses.

Software programs a group with read-modify-write cycles on the register port. The source and destination fields may be set by separate writes. From then on, each qualifying completion pulse on the source channel produces a one-cycle start pulse for the destination channel on the next clock. The 4-bit interrupt-mask field of each group is driven straight out to the channel interrupt logic.

Top module: `dma_chain_trigger`

## Requirements
- R1: After synchronous reset both group words read 0x00000000, `start_req` is all zero and `irq_mask` is zero.
- R2: Group 1 is read and written at byte address 0x28 and group 2 at 0x2C. The word layout is: bits 5:0 source number, bits 13:8 destination number, bits 19:16 trigger select, bits 23:20 interrupt mask, bit 24 enable. Bits 7:6, 15:14 and 31:25 read as zero whatever was written.
- R3: When a group is enabled and its source channel raises a selected done event, the destination's `start_req` bit is high for exactly one cycle, in the cycle after the done pulse is sampled.
- R4: The trigger-select bits map one-hot to events: bit 16 fragment done, bit 17 block done, bit 18 transfer done, bit 19 list done. An unselected event type causes no start. With several bits set, any selected event triggers.
- R5: No start is produced while the enable bit is clear, the trigger select is zero, or the source or destination field is 0.
- R6: Channel fields are one-based. A field value of k refers to channel index k-1 of the done inputs and of `start_req`.
- R7: Done pulses on consecutive cycles each produce their own start pulse on consecutive cycles.
- R8: Starts from different groups are OR-combined per channel. Two groups aimed at the same destination in the same cycle give one pulse on that bit; different destinations pulse together.
- R9: `irq_mask[4*g+3:4*g]` equals bits 23:20 of group g's word.
- R10: A write to any address other than the group words leaves both words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_waddr | input | ADDR_W (12) | Byte address of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | ADDR_W (12) | Byte address of the read |
| cfg_rdata | output | 32 | Read data (combinational, zero for other addresses) |
| done_frag | input | NUM_CH (63) | Per-channel fragment-done pulses |
| done_blk | input | NUM_CH (63) | Per-channel block-done pulses |
| done_xfer | input | NUM_CH (63) | Per-channel transfer-done pulses |
| done_list | input | NUM_CH (63) | Per-channel list-done pulses |
| start_req | output | NUM_CH (63) | Per-channel start-request pulses |
| irq_mask | output | 4*NUM_GRP (8) | Per-group interrupt-mask fields |

## Verification
The assertions assume the done inputs are zero while reset is held. Their start-pulse checks look one cycle back, so that cycle must hold the done and configuration values that caused the pulse. The stimulus drives every input on the falling edge, keeps done lines low during reset, and changes configuration only in cycles with no done pulse. Each table vector therefore sees a stable group setup before its event fires.

// File: rtl/dct_pkg.sv
package dct_pkg;
   localparam int FLD_W    = 6;
   localparam int TRG_W    = 4;
   localparam int IMSK_W   = 4;
   localparam int SRC_LSB  = 0;
   localparam int DST_LSB  = 8;
   localparam int TRG_LSB  = 16;
   localparam int IMSK_LSB = 20;
   localparam int EN_POS   = 24;
   localparam logic [31:0] CFG_MASK = 32'h01FF_3F3F;
endpackage

// File: rtl/dct_cfg_regs.sv
module dct_cfg_regs
   import dct_pkg::*;
#(
   parameter int          NUM_GRP   = 2,
   parameter int          ADDR_W    = 12,
   parameter logic [11:0] BASE_ADDR = 12'h028
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cfg_wr,
   input  logic [ADDR_W-1:0]         cfg_waddr,
   input  logic [31:0]               cfg_wdata,
   input  logic [ADDR_W-1:0]         cfg_raddr,
   output logic [31:0]               cfg_rdata,
   output logic [NUM_GRP-1:0][31:0]  cfg_q
);
   logic [NUM_GRP-1:0] wr_hit;
   logic [NUM_GRP-1:0] rd_hit;

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_word
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR) + ADDR_W'(4 * g);
      assign wr_hit[g] = cfg_wr && (cfg_waddr == MY_ADDR);
      assign rd_hit[g] = (cfg_raddr == MY_ADDR);

      always_ff @(posedge clk) begin
         if (rst)            cfg_q[g] <= '0;
         else if (wr_hit[g]) cfg_q[g] <= cfg_wdata & CFG_MASK;
      end

      assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
         wr_hit[g] |=> (cfg_q[g] == ($past(cfg_wdata) & CFG_MASK)));
   end

   always_comb begin
      cfg_rdata = '0;
      for (int g = 0; g < NUM_GRP; g++)
         if (rd_hit[g]) cfg_rdata = cfg_q[g];
   end

   assert_foreign_write_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (cfg_wr && (wr_hit == '0)) |=> $stable(cfg_q));
endmodule

// File: rtl/dct_group_route.sv
module dct_group_route
   import dct_pkg::*;
#(
   parameter int NUM_CH = 63
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              grp_en,
   input  logic [TRG_W-1:0]  trg_sel,
   input  logic [FLD_W-1:0]  src_num,
   input  logic [FLD_W-1:0]  dst_num,
   input  logic [NUM_CH-1:0] done_frag,
   input  logic [NUM_CH-1:0] done_blk,
   input  logic [NUM_CH-1:0] done_xfer,
   input  logic [NUM_CH-1:0] done_list,
   output logic [NUM_CH-1:0] fire_vec
);
   logic [TRG_W-1:0] src_ev;
   logic             fire;

   // Gather the four event lines of the numbered source (one-based field).
   always_comb begin
      src_ev = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (src_num == FLD_W'(i + 1))
            src_ev = {done_list[i], done_xfer[i], done_blk[i], done_frag[i]};
   end

   assign fire = grp_en && (|(src_ev & trg_sel)) && (dst_num != '0);

   always_comb begin
      fire_vec = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (dst_num == FLD_W'(i + 1)) fire_vec[i] = fire;
   end

   assert_unassigned_silent_R5: assert property (@(posedge clk) disable iff (rst)
      ((src_num == '0) || (dst_num == '0) || !grp_en) |-> (fire_vec == '0));
endmodule

// File: rtl/dma_chain_trigger.sv
module dma_chain_trigger
   import dct_pkg::*;
#(
   parameter int          NUM_CH    = 63,
   parameter int          NUM_GRP   = 2,
   parameter int          ADDR_W    = 12,
   parameter logic [11:0] BASE_ADDR = 12'h028
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cfg_wr,
   input  logic [ADDR_W-1:0]         cfg_waddr,
   input  logic [31:0]               cfg_wdata,
   input  logic [ADDR_W-1:0]         cfg_raddr,
   output logic [31:0]               cfg_rdata,
   input  logic [NUM_CH-1:0]         done_frag,
   input  logic [NUM_CH-1:0]         done_blk,
   input  logic [NUM_CH-1:0]         done_xfer,
   input  logic [NUM_CH-1:0]         done_list,
   output logic [NUM_CH-1:0]         start_req,
   output logic [IMSK_W*NUM_GRP-1:0] irq_mask
);
   localparam int MAX_CH = (1 << FLD_W) - 1;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("NUM_CH must lie in 1..%0d", MAX_CH);
   end
   if (NUM_GRP < 1 || NUM_GRP > 8) begin : g_bad_grp
      $error("NUM_GRP must lie in 1..8");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must be at least 12");
   end

   logic [NUM_GRP-1:0][31:0]     cfg_q;
   logic [NUM_GRP-1:0][NUM_CH-1:0] fire_vec;
   logic [NUM_GRP-1:0]           grp_en;
   logic [NUM_CH-1:0]            start_d;

   dct_cfg_regs #(
      .NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
   ) u_regs (
      .clk(clk), .rst(rst),
      .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
      .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
      .cfg_q(cfg_q)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      assign grp_en[g] = cfg_q[g][EN_POS];
      assign irq_mask[IMSK_W*g +: IMSK_W] = cfg_q[g][IMSK_LSB +: IMSK_W];

      dct_group_route #(.NUM_CH(NUM_CH)) u_route (
         .clk(clk), .rst(rst),
         .grp_en(grp_en[g]),
         .trg_sel(cfg_q[g][TRG_LSB +: TRG_W]),
         .src_num(cfg_q[g][SRC_LSB +: FLD_W]),
         .dst_num(cfg_q[g][DST_LSB +: FLD_W]),
         .done_frag(done_frag), .done_blk(done_blk),
         .done_xfer(done_xfer), .done_list(done_list),
         .fire_vec(fire_vec[g])
      );
   end

   // Per-channel merge of all groups: same destination collapses to one pulse.
   always_comb begin
      start_d = '0;
      for (int g = 0; g < NUM_GRP; g++) start_d = start_d | fire_vec[g];
   end

   always_ff @(posedge clk) begin
      if (rst) start_req <= '0;
      else     start_req <= start_d;
   end

   assert_start_needs_done_R3: assert property (@(posedge clk) disable iff (rst)
      (start_req != '0) |-> $past((done_frag | done_blk | done_xfer | done_list) != '0));

   assert_start_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
      (start_req != '0) |-> $past(grp_en != '0));

   assert_merge_bound_R8: assert property (@(posedge clk) disable iff (rst)
      $countones(start_req) <= NUM_GRP);
endmodule

// File: tb/sim_dma_chain_trigger.sv
module sim_dma_chain_trigger;
   localparam int NCH = 63;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             cfg_wr = 1'b0;
   logic [11:0]      cfg_waddr = '0;
   logic [31:0]      cfg_wdata = '0;
   logic [11:0]      cfg_raddr = '0;
   logic [31:0]      cfg_rdata;
   logic [NCH-1:0]   done_frag = '0, done_blk = '0, done_xfer = '0, done_list = '0;
   logic [NCH-1:0]   start_req;
   logic [7:0]       irq_mask;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   dma_chain_trigger u0 (
      .clk(clk), .rst(rst),
      .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
      .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
      .done_frag(done_frag), .done_blk(done_blk),
      .done_xfer(done_xfer), .done_list(done_list),
      .start_req(start_req), .irq_mask(irq_mask)
   );

   function automatic logic [31:0] mk(int src, int dst, int trg, int en);
      return {7'b0, 1'(en), 4'b0, 4'(trg), 2'b0, 6'(dst), 2'b0, 6'(src)};
   endfunction

   function automatic logic [NCH-1:0] dvec(int d);
      logic [NCH-1:0] v = '0;
      if (d > 0) v[d-1] = 1'b1;
      return v;
   endfunction

   // Vector table: group words, event kind (0 frag,1 blk,2 xfer,3 list),
   // channel index driven, and expected destination numbers (0 = none).
   localparam int NV = 16;
   localparam logic [31:0] TV_C0 [NV] = '{
      mk(3,10,1,1), mk(3,10,1,1), mk(3,10,2,1), mk(3,10,4,1),
      mk(3,10,8,1), mk(3,10,8,1), mk(3,10,1,0), mk(3,10,0,1),
      mk(0,10,1,1), mk(3,0,1,1),  mk(3,10,5,1), 32'h0,
      mk(3,20,1,1), mk(3,20,1,1), mk(2,10,1,1), mk(2,10,1,1)};
   localparam logic [31:0] TV_C1 [NV] = '{
      32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
      32'h0, 32'h0, 32'h0, mk(63,1,2,1),
      mk(3,20,1,1), mk(3,30,1,1), 32'h0, 32'h0};
   localparam int TV_EV  [NV] = '{0,1,1,2, 3,3,0,0, 0,0,2,1, 0,0,0,0};
   localparam int TV_CH  [NV] = '{2,2,2,2, 2,5,2,2, 0,2,2,62, 2,2,2,1};
   localparam int TV_X0  [NV] = '{10,0,10,10, 10,0,0,0, 0,0,10,0, 20,20,0,10};
   localparam int TV_X1  [NV] = '{0,0,0,0, 0,0,0,0, 0,0,0,1, 20,30,0,0};
   localparam string TV_RQ [NV] = '{"R3","R4","R4","R4", "R4","R6","R5","R5",
                                     "R5","R5","R4","R6", "R8","R8","R6","R6"};

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_waddr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      cfg_raddr = a;
      #1;
      d = cfg_rdata;
   endtask

   task automatic drive_ev(int kind, int ch, logic v);
      case (kind)
         0: done_frag[ch] = v;
         1: done_blk[ch]  = v;
         2: done_xfer[ch] = v;
         default: done_list[ch] = v;
      endcase
   endtask

   initial begin
      #(4 * 200000);
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [31:0] rv;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1: reset state
      rd(12'h028, rv); chk("R1", 64'(rv), 64'h0);
      rd(12'h02C, rv); chk("R1", 64'(rv), 64'h0);
      chk("R1", 64'(start_req), 64'h0);
      chk("R1", 64'(irq_mask), 64'h0);

      // R2: layout and reserved bits, per address
      wr(12'h028, 32'hFFFF_FFFF);
      rd(12'h028, rv); chk("R2", 64'(rv), 64'h01FF_3F3F);
      rd(12'h02C, rv); chk("R2", 64'(rv), 64'h0);
      // R9: interrupt-mask fields
      chk("R9", 64'(irq_mask), 64'h0F);
      wr(12'h02C, 32'h0050_0000);
      chk("R9", 64'(irq_mask), 64'h5F);
      // R10: foreign addresses do not disturb the words
      wr(12'h030, 32'h0);
      wr(12'h024, 32'h0);
      wr(12'h128, 32'h0);
      rd(12'h028, rv); chk("R10", 64'(rv), 64'h01FF_3F3F);
      rd(12'h02C, rv); chk("R10", 64'(rv), 64'h0050_0000);

      // Table walk: R3 R4 R5 R6 R8
      for (int v = 0; v < NV; v++) begin
         wr(12'h028, TV_C0[v]);
         wr(12'h02C, TV_C1[v]);
         @(negedge clk);
         drive_ev(TV_EV[v], TV_CH[v], 1'b1);
         @(negedge clk);
         drive_ev(TV_EV[v], TV_CH[v], 1'b0);
         chk(TV_RQ[v], 64'(start_req), 64'(dvec(TV_X0[v]) | dvec(TV_X1[v])));
         @(negedge clk);
         chk("R3", 64'(start_req), 64'h0);
      end

      // R7: three back-to-back done pulses, then quiet
      wr(12'h028, mk(3,10,1,1));
      wr(12'h02C, 32'h0);
      @(negedge clk);
      done_frag[2] = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (k == 2) done_frag[2] = 1'b0;
         chk("R7", 64'(start_req), 64'(dvec(10)));
      end
      @(negedge clk);
      chk("R7", 64'(start_req), 64'h0);

      // R2: fields written by separate writes combine as the final word
      wr(12'h028, mk(5,0,0,0));
      wr(12'h028, mk(5,7,2,1));
      rd(12'h028, rv); chk("R2", 64'(rv), 64'(mk(5,7,2,1)));
      @(negedge clk);
      done_blk[4] = 1'b1;
      @(negedge clk);
      done_blk[4] = 1'b0;
      chk("R6", 64'(start_req), 64'(dvec(7)));

      // R1: reset again clears everything
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      rd(12'h028, rv); chk("R1", 64'(rv), 64'h0);
      chk("R1", 64'(irq_mask), 64'h0);

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule